// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the word-address stream for one DMA channel that walks a rectangular buffer. After a start pulse it latches a byte start address, a line length, a line count and a stride. It then issues one beat per cycle whenever the downstream side is ready. Each line is a run of consecutive 32-bit words, and each new line begins one stride past the start of the line before it. A single-cycle done pulse marks the end of the last line. The current word address can be read at all times, so software can work out how much of a transfer remains.

A line length of zero selects a circular mode for ping-pong buffers. The address climbs through an area of stride × (line count + 1) words and then wraps to the area start, without end. The area is treated as two equal halves, and a separate pulse marks the completion of each half. Two enable bits must both be set for circular traffic to flow. Clearing either bit freezes the walk, and setting both again resumes it from the frozen address. A stop input returns the generator to idle from either mode. Data movement and the memory bus protocol are left to the surrounding channel logic.

Top module: `dma2d_addr_gen`

## Requirements
- R1: On a start pulse while idle, the generator latches the start byte address with its two low bits dropped. The first beat address and the readback address then equal that byte address divided by four.
- R2: In line mode (line length not zero), each line issues exactly line-length beats, at consecutive word addresses.
- R3: Each new line begins at the previous line's start plus the stride in words.
- R4: Line mode issues line count + 1 lines. The done output pulses high for exactly one cycle, in the cycle after the final beat, and the generator is idle in that same cycle.
- R5: A line length of zero selects circular mode. Beats walk from the area start through stride × (line count + 1) words and wrap back to the start. Done is never raised, and the walk continues until stopped.
- R6: In circular mode, half_a_o pulses for one cycle after the beat to word index size/2 − 1 of the area. half_b_o pulses for one cycle after the beat to index size − 1. The two pulses are never high together. The area size must be at least two words.
- R7: In circular mode no beat is issued and the address holds unless loop_en_i equals 2'b11. Restoring 2'b11 resumes from the held address. loop_en_i has no effect in line mode.
- R8: No beat is issued while ready_i is low, and the address and counters advance only on an issued beat.
- R9: stop_i blocks any beat in its own cycle and makes the generator idle in the next cycle, without a done pulse.
- R10: cur_addr_o always shows the word address of the next beat. After the final line-mode beat it shows that beat's address plus one.
- R11: beat_dir_o shows the latched direction bit: 1 for memory to device, 0 for device to memory.
- R12: A start pulse while busy is ignored. The running walk keeps its latched configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| cfg_baddr_i | input | AW | Start byte address |
| cfg_xlen_i | input | LW | Words per line; zero selects circular mode |
| cfg_ylen_i | input | LW | Line count minus one |
| cfg_width_i | input | LW | Stride between line starts, in words |
| cfg_dir_i | input | 1 | Direction, 1 memory to device, 0 device to memory |
| loop_en_i | input | 2 | Circular-mode run enables; both set to run |
| ready_i | input | 1 | Downstream can accept a beat |
| stop_i | input | 1 | Abort to idle |
| beat_o | output | 1 | Beat issued this cycle |
| beat_addr_o | output | AW-2 | Word address of the current beat |
| beat_dir_o | output | 1 | Latched direction |
| cur_addr_o | output | AW-2 | Readback of the next word address |
| busy_o | output | 1 | Generator is running |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| half_a_o | output | 1 | First half of the circular area completed |
| half_b_o | output | 1 | Second half completed, address wrapped |

## Verification
The bench targets the corner cases that an off-by-one error would break. A single-word transfer and a single-line transfer would hang or emit an extra beat if the line-end or last-line compare were wrong. A stride equal to the line length must give a gap-free run; a mistake in stride handling would repeat or skip words. In circular mode, a two-word area and a multi-line area probe the half and wrap events; a wrong threshold would move a pulse by one beat or wrap into the following memory. Random ready and enable gaps check that a paused walk neither advances nor raises done. Stops in mid-transfer and restarts while busy check that a faulty design neither leaks a done pulse nor reloads its configuration.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LINE = 2'd1,
      ST_RING = 2'd2
   } walk_st_e;
endpackage

// File: rtl/dma2d_grid_ctr.sv
// Position inside the rectangle for line mode: word in line, line index.
module dma2d_grid_ctr #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          act_i,
   input  logic          step_i,
   input  logic [LW-1:0] xlen_i,
   input  logic [LW-1:0] ylen_i,
   output logic          line_end_o,
   output logic          last_line_o
);
   generate
      if (LW < 2) begin : g_bad_lw
         $error("dma2d_grid_ctr: LW must be at least 2");
      end
   endgenerate

   logic [LW-1:0] xl_q, yl_q, xc_q, yc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_q <= '0;
         yl_q <= '0;
         xc_q <= '0;
         yc_q <= '0;
      end else if (load_i) begin
         xl_q <= xlen_i;
         yl_q <= ylen_i;
         xc_q <= '0;
         yc_q <= '0;
      end else if (step_i) begin
         if (line_end_o) begin
            xc_q <= '0;
            yc_q <= yc_q + 1'b1;
         end else begin
            xc_q <= xc_q + 1'b1;
         end
      end
   end

   assign line_end_o  = (xc_q == xl_q - 1'b1);
   assign last_line_o = (yc_q == yl_q);

   // R2 / R4: counters stay inside the programmed rectangle while walking
   p_grid_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> ((xc_q < xl_q) && (yc_q <= yl_q)));
endmodule

// File: rtl/dma2d_ring_ctr.sv
// Position inside the circular area; flags the two half boundaries.
module dma2d_ring_ctr #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          act_i,
   input  logic          step_i,
   input  logic [LW-1:0] width_i,
   input  logic [LW-1:0] ylen_i,
   output logic          at_half_o,
   output logic          at_wrap_o
);
   localparam int PW = 2 * LW + 1;

   generate
      if (LW < 2) begin : g_bad_lw
         $error("dma2d_ring_ctr: LW must be at least 2");
      end
   endgenerate

   logic [PW-1:0] size_w, size_q, half_q, pos_q;

   assign size_w = PW'(width_i) * (PW'(ylen_i) + PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         half_q <= '0;
         pos_q  <= '0;
      end else if (load_i) begin
         size_q <= size_w;
         half_q <= size_w >> 1;
         pos_q  <= '0;
      end else if (step_i) begin
         pos_q <= at_wrap_o ? '0 : pos_q + 1'b1;
      end
   end

   assign at_half_o = (pos_q == half_q - 1'b1);
   assign at_wrap_o = (pos_q == size_q - 1'b1);

   // R5: offset never leaves the circular area
   p_ring_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (pos_q < size_q));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int AW = 32,
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] cfg_baddr_i,
   input  logic [LW-1:0] cfg_xlen_i,
   input  logic [LW-1:0] cfg_ylen_i,
   input  logic [LW-1:0] cfg_width_i,
   input  logic          cfg_dir_i,
   input  logic [1:0]    loop_en_i,
   input  logic          ready_i,
   input  logic          stop_i,
   output logic          beat_o,
   output logic [AW-3:0] beat_addr_o,
   output logic          beat_dir_o,
   output logic [AW-3:0] cur_addr_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          half_a_o,
   output logic          half_b_o
);
   import dma2d_pkg::*;

   localparam int WAW = AW - 2;

   generate
      if (WAW <= LW) begin : g_bad_aw
         $error("dma2d_addr_gen: word address must be wider than LW");
      end
   endgenerate

   walk_st_e       st_q;
   logic [WAW-1:0] base_q, line_q, cur_q, wid_w;
   logic [LW-1:0]  wid_q;
   logic           dir_q, done_q, ha_q, hb_q;
   logic           load, in_line, in_ring, run_ok;
   logic           line_end, last_line, at_half, at_wrap;
   logic           unused_lo;

   assign unused_lo = ^cfg_baddr_i[1:0];
   assign load      = start_i && (st_q == ST_IDLE);
   assign in_line   = (st_q == ST_LINE);
   assign in_ring   = (st_q == ST_RING);
   assign run_ok    = in_line || (in_ring && (loop_en_i == 2'b11));
   assign beat_o    = run_ok && ready_i && !stop_i;
   assign wid_w     = {{(WAW-LW){1'b0}}, wid_q};

   dma2d_grid_ctr #(.LW(LW)) u_grid (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .act_i      (in_line),
      .step_i     (beat_o && in_line),
      .xlen_i     (cfg_xlen_i),
      .ylen_i     (cfg_ylen_i),
      .line_end_o (line_end),
      .last_line_o(last_line)
   );

   dma2d_ring_ctr #(.LW(LW)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .act_i    (in_ring),
      .step_i   (beat_o && in_ring),
      .width_i  (cfg_width_i),
      .ylen_i   (cfg_ylen_i),
      .at_half_o(at_half),
      .at_wrap_o(at_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         base_q <= '0;
         line_q <= '0;
         cur_q  <= '0;
         wid_q  <= '0;
         dir_q  <= 1'b0;
         done_q <= 1'b0;
         ha_q   <= 1'b0;
         hb_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ha_q   <= 1'b0;
         hb_q   <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
         end else if (load) begin
            base_q <= cfg_baddr_i[AW-1:2];
            line_q <= cfg_baddr_i[AW-1:2];
            cur_q  <= cfg_baddr_i[AW-1:2];
            wid_q  <= cfg_width_i;
            dir_q  <= cfg_dir_i;
            st_q   <= (cfg_xlen_i == '0) ? ST_RING : ST_LINE;
         end else if (beat_o && in_line) begin
            if (line_end) begin
               if (last_line) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  cur_q  <= cur_q + 1'b1;
               end else begin
                  line_q <= line_q + wid_w;
                  cur_q  <= line_q + wid_w;
               end
            end else begin
               cur_q <= cur_q + 1'b1;
            end
         end else if (beat_o && in_ring) begin
            ha_q  <= at_half;
            hb_q  <= at_wrap;
            cur_q <= at_wrap ? base_q : cur_q + 1'b1;
         end
      end
   end

   assign beat_addr_o = cur_q;
   assign cur_addr_o  = cur_q;
   assign beat_dir_o  = dir_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
   assign half_a_o    = ha_q;
   assign half_b_o    = hb_q;

   p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |-> !beat_o);
   p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!busy_o && !done_o));
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_ring_nodone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ring |-> !done_o);
   p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ring && (loop_en_i != 2'b11)) |=> $stable(cur_addr_o));
   p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_o && in_line && !line_end) |=> (cur_addr_o == $past(cur_addr_o) + 1'b1));
   p_base_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(base_q));
   p_half_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(half_a_o && half_b_o));
endmodule

// File: tb/sim_dma2d_addr_gen.sv
`timescale 1ns/1ps
module sim_dma2d_addr_gen;
   localparam int AW = 32;
   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] baddr = '0;
   logic [LW-1:0] xlen = '0, ylen = '0, width = '0;
   logic          dir = 1'b0;
   logic [1:0]    loop_en = 2'b00;
   logic          ready = 1'b0;
   logic          stop = 1'b0;
   logic          beat_o, beat_dir_o, busy_o, done_o, half_a_o, half_b_o;
   logic [AW-3:0] beat_addr_o, cur_addr_o;

   int nchk = 0;
   int nbad = 0;
   bit summary_done = 1'b0;

   always #4 clk = ~clk;

   dma2d_addr_gen #(.AW(AW), .LW(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_baddr_i(baddr),
      .cfg_xlen_i(xlen), .cfg_ylen_i(ylen), .cfg_width_i(width),
      .cfg_dir_i(dir), .loop_en_i(loop_en), .ready_i(ready), .stop_i(stop),
      .beat_o(beat_o), .beat_addr_o(beat_addr_o), .beat_dir_o(beat_dir_o),
      .cur_addr_o(cur_addr_o), .busy_o(busy_o), .done_o(done_o),
      .half_a_o(half_a_o), .half_b_o(half_b_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
      end
   endtask

   function automatic longint line_addr(longint base, int k, int x, int w);
      return base + longint'(k / x) * w + (k % x);
   endfunction

   // line mode run; stop_after >= 0 stops when that many beats are done;
   // restart_at >= 0 pulses start with a different config in that cycle
   task automatic run_line(input int b, input int x, input int y, input int w,
                           input bit d, input int rdy_pct, input int stop_after,
                           input int restart_at);
      longint base = longint'(b) >> 2;
      int total = x * (y + 1);
      int k = 0;
      int dones = 0;
      bit prev_last = 1'b0;
      longint expa;
      @(negedge clk);
      baddr = b; xlen = x; ylen = y; width = w; dir = d; start = 1'b1; ready = 1'b0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         start = (cyc == restart_at);
         baddr = (cyc == restart_at) ? b + 512 : b;
         xlen  = (cyc == restart_at) ? x + 2 : x;
         dir   = (cyc == restart_at) ? ~d : d;
         ready = (($urandom % 100) < rdy_pct);
         loop_en = 2'($urandom % 4);          // R7: ignored in line mode
         stop  = (stop_after >= 0 && k == stop_after);
         #1;
         if (cyc == 0) chk(cur_addr_o == base, "R1 readback after start", cur_addr_o, base);
         chk(done_o == prev_last, "R4 done timing", done_o, prev_last);
         if (done_o) dones++;
         if (!busy_o) begin
            chk(k == total, "R4 beat count", k, total);
            chk(dones == 1, "R4 single done", dones, 1);
            expa = base + longint'(y) * w + x;
            chk(cur_addr_o == expa, "R10 final readback", cur_addr_o, expa);
            break;
         end
         expa = line_addr(base, k, x, w);
         chk(cur_addr_o == expa, "R10 readback", cur_addr_o, expa);
         if (!ready) chk(!beat_o, "R8 ready low", beat_o, 0);
         if (stop) begin
            chk(!beat_o, "R9 no beat while stopping", beat_o, 0);
            @(negedge clk);
            stop = 1'b0;
            #1;
            chk(!busy_o, "R9 idle after stop", busy_o, 0);
            chk(!done_o, "R9 no done on stop", done_o, 0);
            break;
         end
         prev_last = 1'b0;
         if (beat_o) begin
            chk(beat_addr_o == expa, "R2 R3 beat address", beat_addr_o, expa);
            chk(beat_dir_o == d, "R11 direction", beat_dir_o, d);
            prev_last = (k == total - 1);
            k++;
         end
      end
      stop = 1'b0; start = 1'b0; ready = 1'b0;
   endtask

   task automatic run_ring(input int b, input int y, input int w, input int nbeats,
                           input bit do_pause, input bit d);
      longint base = longint'(b) >> 2;
      int size = w * (y + 1);
      int half = size / 2;
      int pos = 0;
      int k = 0;
      bit ea = 1'b0, eb = 1'b0;
      @(negedge clk);
      baddr = b; xlen = '0; ylen = y; width = w; dir = d; loop_en = 2'b11;
      start = 1'b1; ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(busy_o, "R5 circular mode busy", busy_o, 1);
      chk(cur_addr_o == base, "R1 circular start address", cur_addr_o, base);
      for (int cyc = 0; cyc < 8000 && k < nbeats; cyc++) begin
         @(negedge clk);
         ready = (($urandom % 100) < 75);
         loop_en = (do_pause && ($urandom % 4 == 0)) ? 2'($urandom % 3) : 2'b11;
         #1;
         chk(half_a_o == ea, "R6 first half event", half_a_o, ea);
         chk(half_b_o == eb, "R6 second half event", half_b_o, eb);
         chk(!done_o, "R5 no done in circular mode", done_o, 0);
         chk(busy_o, "R5 keeps running", busy_o, 1);
         chk(cur_addr_o == base + pos, "R10 circular readback", cur_addr_o, base + pos);
         ea = 1'b0; eb = 1'b0;
         if (loop_en != 2'b11) chk(!beat_o, "R7 paused", beat_o, 0);
         if (!ready) chk(!beat_o, "R8 ready low", beat_o, 0);
         if (beat_o) begin
            chk(beat_addr_o == base + pos, "R5 circular address", beat_addr_o, base + pos);
            chk(beat_dir_o == d, "R11 direction", beat_dir_o, d);
            ea = (pos == half - 1);
            eb = (pos == size - 1);
            pos = eb ? 0 : pos + 1;
            k++;
         end
      end
      chk(k == nbeats, "R5 circular progress", k, nbeats);
      @(negedge clk);
      stop = 1'b1; ready = 1'b1; loop_en = 2'b11;
      #1;
      chk(!beat_o, "R9 no beat while stopping", beat_o, 0);
      @(negedge clk);
      stop = 1'b0; ready = 1'b0;
      #1;
      chk(!busy_o, "R9 idle after stop", busy_o, 0);
      chk(!done_o, "R9 no done on stop", done_o, 0);
   endtask

   initial begin
      #(8 * 150000);
      nbad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk(!busy_o, "R1 reset idle", busy_o, 0);
      chk(!beat_o && !done_o, "R4 reset outputs", {beat_o, done_o}, 0);
      chk(cur_addr_o == 0, "R10 reset readback", cur_addr_o, 0);
      rst_n = 1'b1;

      run_line(32'h1000, 4, 2, 8, 1'b1, 100, -1, -1);   // R2 R3 plain
      run_line(32'h2003, 1, 0, 1, 1'b0, 60, -1, -1);    // R1 low bits dropped, one word
      run_line(32'h0400, 5, 3, 5, 1'b1, 50, -1, -1);    // stride equals line length
      run_line(32'h0800, 3, 4, 10, 1'b0, 70, -1, 3);    // R12 restart while busy
      run_line(32'h0C00, 6, 2, 9, 1'b1, 80, 7, -1);     // R9 stop mid-run
      for (int i = 0; i < 6; i++) begin
         automatic int x = 1 + int'($urandom % 6);
         automatic int y = int'($urandom % 5);
         automatic int w = x + int'($urandom % 4);
         run_line(32'h4000 + i * 64, x, y, w, 1'($urandom % 2), 65, -1, -1);
      end
      run_ring(32'h3000, 7, 1, 20, 1'b1, 1'b0);   // R5 R6 R7
      run_ring(32'h3100, 3, 3, 30, 1'b1, 1'b1);   // 12-word area
      run_ring(32'h3200, 1, 1, 7, 1'b0, 1'b0);    // two-word area
      run_line(32'h5000, 2, 1, 4, 1'b0, 100, -1, -1);  // line mode after circular
      summary();
      $finish;
   end
endmodule